// File: doc/BRIEF.md
# Debug-Mode Fetch Permission Gate

This block tracks whether a hart is in debug mode and decides, for every instruction fetch, whether the fetch may enter the debug ROM window. An external halt request is taken as a trap into debug mode. On that same cycle the hart's next fetch is redirected to the debug ROM entry at 0x800. The block keeps a registered debug flag. The flag is set by the trap and cleared by a debug-return pulse.

The status handed to the permission check is the trap event ORed with the registered flag. A fetch issued in the same cycle as the trap therefore already sees debug mode and is granted. A status driven only by the register would lag one clock behind. In that case the first debug ROM fetch would be refused, an instruction access fault would follow, and the halt would fail.

The parameter `FWD_STATUS` selects between the forwarded status (default, 1) and a registered-only status (0). The registered-only form is kept so that the lagging behaviour can be reproduced. The mode tracker is a two-state machine:

- State `DBG_RUN`: normal execution.
- State `DBG_HALTED`: debug mode.
- Transition *enter* (`DBG_RUN` to `DBG_HALTED`): taken on a clock edge where `halt_req` is high.
- Transition *resume* (`DBG_HALTED` to `DBG_RUN`): taken on an edge where `dret` is high and `halt_req` is low.
- Transition *re-enter*: `DBG_HALTED` holds when `halt_req` and `dret` are high together.

Top module: `fetch_gate_top`

## Requirements
- R1: After reset the machine is in `DBG_RUN`, `dbg_status` is 0, and a valid fetch to 0x800 with `halt_req` low is faulted.
- R2: With `FWD_STATUS`=1, `dbg_status` is 1 in every cycle where `halt_req` is 1, including the first one.
- R3: A valid fetch to 0x800 in the same cycle as `halt_req` gets `fetch_grant`=1 and `fetch_fault`=0.
- R4: After a trap, `dbg_status` stays 1 on every following cycle until a debug return takes effect.
- R5: A `dret` pulse with `halt_req` low returns to `DBG_RUN` at the next clock edge. Fetches in the return cycle are still granted. From the following cycle, fetches into the window fault.
- R6: When `halt_req` and `dret` are both high in one cycle, the trap wins: `dbg_status` is 1 on the next cycle.
- R7: The debug ROM window is 0x800 to 0xFFF inclusive. A valid fetch inside it faults when `dbg_status` is 0. Addresses 0x7FF and 0x1000 lie outside it.
- R8: A valid fetch outside the window is always granted, whatever the debug state.
- R9: `fetch_grant` and `fetch_fault` are 0 whenever `fetch_valid` is 0. When `fetch_valid` is 1, exactly one of them is 1, for that cycle only.
- R10: With `FWD_STATUS`=0, `dbg_status` follows only the registered flag, so a valid fetch to 0x800 in the halt cycle is faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request; high means a trap to debug in this cycle |
| dret | input | 1 | Debug-return pulse |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_grant | output | 1 | Fetch permitted |
| fetch_fault | output | 1 | Fetch refused; instruction access fault |
| dbg_status | output | 1 | Debug status as seen by the permission check |

## Verification
The assertions take `halt_req` and `dret` as level inputs sampled on each rising edge, and `fetch_addr` as meaningful only while `fetch_valid` is high. They make no assumption that halt and return are exclusive. The stimulus changes every input only on the falling edge, so the combinational grant, fault and status are settled well before the next rising edge. The stimulus deliberately drives halt and return together, to cover the priority rule. It also drives the window boundaries 0x7FF, 0x800, 0xFFF and 0x1000. A pseudo-random run then mixes addresses both in and out of the window with sparse halts and returns.

// File: rtl/fetch_gate_pkg.sv
package fetch_gate_pkg;

    typedef enum logic {
        DBG_RUN    = 1'b0,
        DBG_HALTED = 1'b1
    } dbg_state_e;

    typedef struct packed {
        logic grant;
        logic fault;
    } fetch_verdict_t;

endpackage

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import fetch_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic dret,
    output logic trap_now,
    output logic flag_q
);

    dbg_state_e state_q;
    dbg_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DBG_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enter, resume, re-enter (trap beats return)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DBG_RUN: begin
                if (halt_req) begin
                    state_d = DBG_HALTED;
                end
            end
            DBG_HALTED: begin
                if (dret && !halt_req) begin
                    state_d = DBG_RUN;
                end
            end
            default: state_d = DBG_RUN;
        endcase
    end

    // outputs
    always_comb begin
        trap_now = halt_req;
        flag_q   = (state_q == DBG_HALTED);
    end

endmodule

// File: rtl/dbg_rom_window.sv
module dbg_rom_window #(
    parameter int unsigned          ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]    ROM_BASE = 'h800,
    parameter logic [ADDR_W-1:0]    ROM_LAST = 'hFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window
);

    always_comb begin
        in_window = (addr >= ROM_BASE) && (addr <= ROM_LAST);
    end

endmodule

// File: rtl/fetch_perm_check.sv
module fetch_perm_check
    import fetch_gate_pkg::*;
(
    input  logic           fetch_valid,
    input  logic           in_window,
    input  logic           status,
    output fetch_verdict_t verdict
);

    always_comb begin
        verdict.grant = fetch_valid && (!in_window || status);
        verdict.fault = fetch_valid && in_window && !status;
    end

endmodule

// File: rtl/fetch_gate_top.sv
module fetch_gate_top
    import fetch_gate_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]    ROM_BASE   = 'h800,
    parameter logic [ADDR_W-1:0]    ROM_LAST   = 'hFFF,
    parameter bit                   FWD_STATUS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              dret,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_grant,
    output logic              fetch_fault,
    output logic              dbg_status
);

    logic           trap_now;
    logic           flag_q;
    logic           in_window;
    logic           status;
    fetch_verdict_t verdict;

    dbg_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .dret     (dret),
        .trap_now (trap_now),
        .flag_q   (flag_q)
    );

    dbg_rom_window #(
        .ADDR_W   (ADDR_W),
        .ROM_BASE (ROM_BASE),
        .ROM_LAST (ROM_LAST)
    ) u_win (
        .addr      (fetch_addr),
        .in_window (in_window)
    );

    generate
        if (FWD_STATUS) begin : g_fwd
            always_comb status = trap_now || flag_q;
        end else begin : g_reg
            logic unused_trap;
            always_comb begin
                unused_trap = trap_now;
                status      = flag_q;
            end
        end
    endgenerate

    fetch_perm_check u_chk (
        .fetch_valid (fetch_valid),
        .in_window   (in_window),
        .status      (status),
        .verdict     (verdict)
    );

    always_comb begin
        fetch_grant = verdict.grant;
        fetch_fault = verdict.fault;
        dbg_status  = status;
    end

endmodule

// File: rtl/fetch_gate_chk.sv
module fetch_gate_chk #(
    parameter int unsigned          ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]    ROM_BASE   = 'h800,
    parameter logic [ADDR_W-1:0]    ROM_LAST   = 'hFFF,
    parameter bit                   FWD_STATUS = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_req,
    input logic              dret,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_grant,
    input logic              fetch_fault,
    input logic              dbg_status
);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (!fetch_grant && !fetch_fault));

    // R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> $onehot({fetch_grant, fetch_fault}));

    // R8
    outside_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && ((fetch_addr < ROM_BASE) || (fetch_addr > ROM_LAST))) |-> fetch_grant);

    // R4
    halt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> dbg_status);

    // R4
    hold_until_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status && !dret) |=> dbg_status);

    // R5
    ret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dret && !halt_req) |=> (!dbg_status || halt_req));

    generate
        if (FWD_STATUS) begin : g_fwd_chk
            // R2
            same_cycle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
                halt_req |-> dbg_status);
        end
    endgenerate

endmodule

bind fetch_gate_top fetch_gate_chk #(
    .ADDR_W     (ADDR_W),
    .ROM_BASE   (ROM_BASE),
    .ROM_LAST   (ROM_LAST),
    .FWD_STATUS (FWD_STATUS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .dret        (dret),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_grant (fetch_grant),
    .fetch_fault (fetch_fault),
    .dbg_status  (dbg_status)
);

// File: tb/fetch_gate_top_tb_top.sv
module fetch_gate_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              halt_req = 1'b0;
    logic              dret = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              grant_f, fault_f, status_f;
    logic              grant_r, fault_r, status_r;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    bit model_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_gate_top #(.ADDR_W(ADDR_W), .FWD_STATUS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dret(dret),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_grant(grant_f), .fetch_fault(fault_f), .dbg_status(status_f)
    );

    fetch_gate_top #(.ADDR_W(ADDR_W), .FWD_STATUS(1'b0)) lag_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .dret(dret),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_grant(grant_r), .fetch_fault(fault_r), .dbg_status(status_r)
    );

    function automatic bit in_rom(input logic [ADDR_W-1:0] a);
        return (a >= 'h800) && (a <= 'hFFF);
    endfunction

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, compare, then advance the model at the rising edge
    task automatic step(input string tag, input bit h, input bit r, input bit v,
                        input logic [ADDR_W-1:0] a);
        bit st_f, st_r, win;
        @(negedge clk);
        halt_req = h; dret = r; fetch_valid = v; fetch_addr = a;
        #1;
        win  = in_rom(a);
        st_f = h || model_flag;
        st_r = model_flag;
        cmp(tag, "fwd status", status_f, st_f);
        cmp(tag, "fwd grant",  grant_f,  v && (!win || st_f));
        cmp(tag, "fwd fault",  fault_f,  v && win && !st_f);
        cmp(tag, "reg status", status_r, st_r);
        cmp(tag, "reg grant",  grant_r,  v && (!win || st_r));
        cmp(tag, "reg fault",  fault_r,  v && win && !st_r);
        @(posedge clk);
        if (h) model_flag = 1'b1;
        else if (r) model_flag = 1'b0;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_flag = 1'b0;

        // R1 reset state: window fetch faults
        step("R1", 0, 0, 1, 'h800);
        // R7 boundaries with status low
        step("R7", 0, 0, 1, 'h7FF);
        step("R7", 0, 0, 1, 'hFFF);
        step("R7", 0, 0, 1, 'h1000);
        // R8 far outside
        step("R8", 0, 0, 1, 'h0);
        step("R8", 0, 0, 1, 'h8000_0000);
        // R9 no fetch, no verdict
        step("R9", 0, 0, 0, 'h800);
        // R3 halt and fetch together; R10 lagging variant faults here
        step("R3", 1, 0, 1, 'h800);
        // R4 flag keeps debug status
        step("R4", 0, 0, 1, 'h800);
        step("R4", 0, 0, 1, 'hFFF);
        step("R9", 0, 0, 0, 'hA00);
        // R5 return cycle still granted, then fault
        step("R5", 0, 1, 1, 'h900);
        step("R5", 0, 0, 1, 'h900);
        // R10 registered-only variant in a second halt cycle
        step("R10", 1, 0, 1, 'h800);
        // R6 halt and return together: trap wins
        step("R6", 1, 1, 1, 'h800);
        step("R6", 0, 0, 1, 'h800);
        step("R5", 0, 1, 0, 'h0);
        // R6 from run state with both high
        step("R6", 1, 1, 1, 'hC00);
        step("R6", 0, 0, 1, 'hC00);
        step("R5", 0, 1, 1, 'h7FF);
        // R2 status in the halt cycle, no fetch
        step("R2", 1, 0, 0, 'h0);
        step("R5", 0, 1, 0, 'h0);
        step("R1", 0, 0, 1, 'hFFF);

        // R8 mixed stimulus
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R8", lfsr[3:0] == 4'h5, lfsr[7:4] == 4'h9, lfsr[8],
                 {20'h0, lfsr[15:13] == 3'b000 ? 4'h1 : 4'h0, lfsr[11:4]} + 32'h700);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule